// File: doc/BRIEF.md
# Shift Carry Control Unit

This block computes the carry bit handed to the shifter when a destination-store microinstruction executes, and it owns the carry flip-flop that such instructions update. Three fields of the 16-bit instruction word steer it: a two-bit carry-control code, a three-bit ALU function code and a no-load bit. The carry-control code chooses a base carry, which is the current flip-flop value, 0, 1, or the complement of the current value. The ALU function code then decides whether the ALU carry-out may invert that base carry.

The result is valid after the ALU has produced its carry-out and before the shift happens. It goes out as the shifter carry-in. On the next clock edge it is stored in the carry flip-flop, unless the no-load bit is set. That bit also cancels the result register write, and it takes precedence over any ordinary load-register request present in the same cycle. When the store strobe is low, the block passes the ordinary load request through and leaves the carry untouched.

Top module: `shift_carry_ctrl`

## Requirements
- R1: The carry-control code sits in instruction bits 5:4. Code 0 selects the current carry, 1 selects 0, 2 selects 1, and 3 selects the complement of the current carry.
- R2: For ALU function codes 0, 2 and 7 in instruction bits 10:8, the shifter carry-in equals the selected carry, whatever the ALU carry-out is.
- R3: For ALU function codes 1, 3, 4, 5 and 6, the shifter carry-in is the complement of the selected carry when the ALU carry-out is 1.
- R4: For ALU function codes 1, 3, 4, 5 and 6, the shifter carry-in equals the selected carry when the ALU carry-out is 0.
- R5: Strobe high with instruction bit 3 set drives the register write enable low, even when the load request is high. In that case the carry flip-flop keeps its value across the edge.
- R6: Strobe low makes the register write enable follow the load request, and the carry flip-flop keeps its value across the edge.
- R7: Strobe high with instruction bit 3 clear drives the register write enable high. In that case the carry flip-flop takes the shifter carry-in at the next rising edge.
- R8: Reset low clears the carry flip-flop at once. After reset rises, the flip-flop stays cleared for SYNC_STAGES rising edges, then updates normally.
- R9: The next-carry output equals the shifter carry-in when an update is due, and the current carry otherwise. Instruction bits 15:11, 7:6 and 2:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| store_strobe_i | input | 1 | Destination-store microinstruction active |
| load_req_i | input | 1 | Ordinary load-register request |
| alu_cout_i | input | 1 | ALU carry-out of the current operation |
| shift_cin_o | output | 1 | Carry handed to the shifter |
| reg_we_o | output | 1 | Result register write enable |
| carry_nxt_o | output | 1 | Value the carry flip-flop takes at the next edge |
| carry_q_o | output | 1 | Current carry flip-flop |

## Verification
The hardest case to reach from the ports is the window after reset is released. During that window a strobed load must be refused, because the synchronized reset still holds the flip-flop. The bench asserts reset in the middle of a run, with the carry at 1, and checks that the carry clears before any edge. It then releases reset together with a strobe that forces a 1, and samples the carry after each edge until the first edge at which the update may take effect. The inverting classes are reached by sweeping every carry-control code against every ALU code and both carry-out values. The carry state feeds back from one item to the next, so both starting values of the flip-flop get exercised.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;
  localparam int CTL_LSB    = 4;
  localparam int OP_LSB     = 8;
  localparam int NOLOAD_BIT = 3;
  localparam int OP_W       = 3;
  localparam int OP_CODES   = 1 << OP_W;

  typedef enum logic [1:0] {
    CY_KEEP = 2'd0,
    CY_ZERO = 2'd1,
    CY_ONE  = 2'd2,
    CY_FLIP = 2'd3
  } cy_ctl_e;

  typedef struct packed {
    logic [OP_W-1:0] op;
    cy_ctl_e         ctl;
    logic            no_load;
  } instr_fields_t;
endpackage

// File: rtl/scc_rst_sync.sv
`timescale 1ns/1ps
module scc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_q_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_q_no = sync_q[STAGES-1];
endmodule

// File: rtl/scc_decode.sv
`timescale 1ns/1ps
module scc_decode
  import scc_pkg::*;
#(
  parameter int IR_W = 16
) (
  input  logic [IR_W-1:0] instr_i,
  output instr_fields_t   fields_o
);
  always_comb begin
    fields_o.op      = instr_i[OP_LSB +: OP_W];
    fields_o.ctl     = cy_ctl_e'(instr_i[CTL_LSB +: 2]);
    fields_o.no_load = instr_i[NOLOAD_BIT];
  end
endmodule

// File: rtl/scc_carry_sel.sv
`timescale 1ns/1ps
module scc_carry_sel
  import scc_pkg::*;
#(
  parameter logic [OP_CODES-1:0] INV_MASK = 8'h7A
) (
  input  cy_ctl_e         ctl_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_i,
  input  logic            alu_cout_i,
  output logic            cin_o
);
  logic [OP_CODES-1:0] op_hit;
  logic                base;
  logic                flip;

  genvar gi;
  generate
    for (gi = 0; gi < OP_CODES; gi++) begin : g_op
      assign op_hit[gi] = INV_MASK[gi] && (op_i == OP_W'(gi));
    end
  endgenerate

  always_comb begin
    unique case (ctl_i)
      CY_KEEP: base = carry_i;
      CY_ZERO: base = 1'b0;
      CY_ONE:  base = 1'b1;
      default: base = ~carry_i;
    endcase
    flip  = (|op_hit) & alu_cout_i;
    cin_o = base ^ flip;
  end
endmodule

// File: rtl/shift_carry_ctrl.sv
`timescale 1ns/1ps
module shift_carry_ctrl
  import scc_pkg::*;
#(
  parameter int                  IR_W        = 16,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [OP_CODES-1:0] INV_MASK    = 8'h7A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] instr_i,
  input  logic            store_strobe_i,
  input  logic            load_req_i,
  input  logic            alu_cout_i,
  output logic            shift_cin_o,
  output logic            reg_we_o,
  output logic            carry_nxt_o,
  output logic            carry_q_o
);
  logic          rst_q_n;
  instr_fields_t fields;
  logic          cin;
  logic          upd_en;
  logic          carry_d;
  logic          carry_q;

  scc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rst_q_no(rst_q_n)
  );

  scc_decode #(.IR_W(IR_W)) u_dec (
    .instr_i (instr_i),
    .fields_o(fields)
  );

  scc_carry_sel #(.INV_MASK(INV_MASK)) u_sel (
    .ctl_i     (fields.ctl),
    .op_i      (fields.op),
    .carry_i   (carry_q),
    .alu_cout_i(alu_cout_i),
    .cin_o     (cin)
  );

  always_comb begin
    upd_en   = store_strobe_i & ~fields.no_load;
    carry_d  = upd_en ? cin : carry_q;
    reg_we_o = store_strobe_i ? ~fields.no_load : load_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n)    carry_q <= 1'b0;
    else if (upd_en) carry_q <= carry_d;
  end

  assign shift_cin_o = cin;
  assign carry_nxt_o = carry_d;
  assign carry_q_o   = carry_q;
endmodule

// File: rtl/scc_checker.sv
`timescale 1ns/1ps
module scc_checker (
  input logic        clk_i,
  input logic        rst_q_n,
  input logic [15:0] instr_i,
  input logic        store_strobe_i,
  input logic        load_req_i,
  input logic        shift_cin_o,
  input logic        reg_we_o,
  input logic        carry_nxt_o,
  input logic        carry_q_o
);
  AST_SKIP_KEEPS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (store_strobe_i && instr_i[3]) |=> $stable(carry_q_o)); // R5

  AST_SKIP_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (store_strobe_i && instr_i[3] && load_req_i) |-> !reg_we_o); // R5

  AST_IDLE_KEEPS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !store_strobe_i |=> $stable(carry_q_o)); // R6

  AST_IDLE_WE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !store_strobe_i |-> (reg_we_o == load_req_i)); // R6

  AST_STORE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (store_strobe_i && !instr_i[3]) |=> (carry_q_o == $past(shift_cin_o))); // R7

  AST_MOV_KEEP_PASS: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (instr_i[10:8] == 3'd2 && instr_i[5:4] == 2'd0) |-> (shift_cin_o == carry_q_o)); // R2

  AST_FORCE_ONE_PASS: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (instr_i[10:8] == 3'd7 && instr_i[5:4] == 2'd2) |-> shift_cin_o); // R1

  AST_NEXT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !store_strobe_i |-> (carry_nxt_o == carry_q_o)); // R9
endmodule

bind shift_carry_ctrl scc_checker u_chk (
  .clk_i         (clk_i),
  .rst_q_n       (rst_q_n),
  .instr_i       (instr_i),
  .store_strobe_i(store_strobe_i),
  .load_req_i    (load_req_i),
  .shift_cin_o   (shift_cin_o),
  .reg_we_o      (reg_we_o),
  .carry_nxt_o   (carry_nxt_o),
  .carry_q_o     (carry_q_o)
);

// File: tb/shift_carry_ctrl_bench.sv
`timescale 1ns/1ps
module shift_carry_ctrl_bench;
  localparam int SYNC_STAGES = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr;
  logic        strobe;
  logic        load_req;
  logic        alu_cout;
  logic        shift_cin;
  logic        reg_we;
  logic        carry_nxt;
  logic        carry_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic exp_carry = 1'b0;

  typedef struct {
    logic  cin;
    logic  we;
    logic  nxt;
    logic  cur;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  shift_carry_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_shift_carry_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .instr_i       (instr),
    .store_strobe_i(strobe),
    .load_req_i    (load_req),
    .alu_cout_i    (alu_cout),
    .shift_cin_o   (shift_cin),
    .reg_we_o      (reg_we),
    .carry_nxt_o   (carry_nxt),
    .carry_q_o     (carry_q)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Bits 15:11, 7:6 and 2:0 are filled with junk the design must ignore (R9).
  function automatic logic [15:0] mk(logic [2:0] op, logic [1:0] ctl, logic nl, logic [4:0] junk);
    return {junk, op, junk[1:0], ctl, nl, junk[2:0]};
  endfunction

  task automatic apply(logic [2:0] op, logic [1:0] ctl, logic nl, logic stb,
                       logic ld, logic co, logic [4:0] junk);
    exp_t e;
    logic sel;
    logic inv;
    @(negedge clk);
    instr = mk(op, ctl, nl, junk); strobe = stb; load_req = ld; alu_cout = co;
    case (ctl)
      2'd0: sel = exp_carry;
      2'd1: sel = 1'b0;
      2'd2: sel = 1'b1;
      default: sel = ~exp_carry;
    endcase
    inv   = (op == 3'd1 || op == 3'd3 || op == 3'd4 || op == 3'd5 || op == 3'd6);
    e.cin = sel ^ (inv & co);
    e.we  = stb ? ~nl : ld;
    e.nxt = (stb && !nl) ? e.cin : exp_carry;
    e.cur = exp_carry;
    if (!stb)       e.tag = "R6";
    else if (nl)    e.tag = "R5";
    else if (!inv)  e.tag = "R2 R1 R7";
    else if (co)    e.tag = "R3 R1 R7";
    else            e.tag = "R4 R1 R7";
    sb.push_back(e);
    exp_carry = e.nxt;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "shift_cin", shift_cin, e.cin);
        check(e.tag, "reg_we", reg_we, e.we);
        check({e.tag, " R9"}, "carry_nxt", carry_nxt, e.nxt);
        check(e.tag, "carry_q", carry_q, e.cur);
      end
    end
  end

  initial begin : watchdog
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; instr = '0; strobe = 1'b0; load_req = 1'b0; alu_cout = 1'b0;
    #15;
    check("R8", "carry_q in reset", carry_q, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (SYNC_STAGES + 2) @(negedge clk);

    // Full sweep: every control code, ALU code and carry-out, with store active.
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 8; o++)
        for (int k = 0; k < 2; k++)
          apply(3'(o), 2'(c), 1'b0, 1'b1, 1'b0, k[0], 5'(o * 7 + c));

    // Force carry to 1, then no-load with load request high.
    apply(3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'h1F);
    apply(3'd5, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 5'h0A);
    apply(3'd0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 5'h15);
    // Strobe low: write enable follows the load request, carry held.
    apply(3'd6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 5'h03);
    apply(3'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'h1C);
    apply(3'd7, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 5'h00);
    apply(3'd4, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'h11);
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    repeat (2) @(negedge clk);

    // Mid-run reset with carry at 1 (R8).
    check("R8", "carry_q before reset", carry_q, 1'b1);
    #2 rst_n = 1'b0;
    #3 check("R8", "carry_q async clear", carry_q, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; instr = mk(3'd0, 2'd2, 1'b0, 5'h00); strobe = 1'b1;
    @(posedge clk); #5 check("R8", "carry_q after edge 1", carry_q, 1'b0);
    @(posedge clk); #5 check("R8", "carry_q after edge 2", carry_q, 1'b0);
    @(posedge clk); #5 check("R8 R7", "carry_q after edge 3", carry_q, 1'b1);
    @(negedge clk); strobe = 1'b0;
    exp_carry = 1'b1;
    apply(3'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 5'h09);
    apply(3'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 5'h09);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule